// File: doc/BRIEF.md
# Interrupt Line Register File

This block is the memory-mapped front end of an interrupt controller serving up to 64 interrupt lines. Software reaches it over a simple 32-bit register bus. Each per-line setting is held as a 64-bit quantity: mask, edge select, message enable, polarity, request and in-service. Every such setting appears on the bus as a low word at its base offset and a high word four bytes above it. The block conditions each input with its polarity bit. Lines set to edge latch a request on an active transition. Level lines track the input. The block drives a vector of unmasked active requests to a downstream router.

A two-state access machine handles the bus. In `ST_IDLE` no read data is presented. Accepting a read moves it to `ST_RDATA` (transition *read accepted*), where the registered word is shown with `rd_valid` for one cycle. Another read accepted in `ST_RDATA` keeps it there (*back-to-back read*). Any other cycle returns it to `ST_IDLE` (*read retired*). A write is applied at the clock edge that accepts it and moves the machine to `ST_IDLE`.

Top module: `intc_regs`

## Requirements
- R1: A read accepted at a clock edge (`bus_valid`=1, `bus_write`=0) presents its data on `rd_data` with `rd_valid`=1 during the following cycle. `rd_valid` is 0 in any cycle that does not follow an accepted read. A write updates its register at the accepting edge.
- R2: Each 64-bit setting is two words: bits 31:0 sit at the base offset and bits 63:32 at base+4. The base offsets are: ident 0x000, mask 0x020, message enable 0x040, edge select 0x060, clear 0x080, in-service status 0x3A0 and polarity 0x3E0. Bit n of a setting belongs to line n.
- R3: Reading offset 0x000 returns 0x0700_0000.
- R4: Reading offset 0x004 returns 0x0001 in bits 15:0 and NUM_LINES-1 in bits 31:16.
- R5: A write to the mask, edge-select, message-enable or polarity words changes only the addressed half. The other half keeps its value.
- R6: Words 0x0C0, 0x0C4, 0x0E0 and 0x0E4 accept writes with no effect and read as zero. The same holds for every other unmapped or misaligned offset and for the clear words.
- R7: After reset every mask bit is 1, edge select, message enable, polarity, request and in-service are 0, and `irq_out` is 0.
- R8: A polarity bit of 1 makes its line active when the input is low. A polarity bit of 0 makes it active when the input is high.
- R9: A line with edge select 1 latches a request at the first edge after its polarity-adjusted input goes from inactive to active. The request holds after the input returns inactive.
- R10: A line with edge select 0 has a request equal to its polarity-adjusted input as sampled at the previous edge.
- R11: `irq_out` bit n is the request of line n AND NOT mask bit n. Clearing a mask bit exposes a request latched while the line was masked, from the cycle after the write.
- R12: A 1 written to a clear word removes both the request and the in-service bit, but only for edge-select lines. Bits for level lines have no effect.
- R13: The status words show in-service bits. An edge line's bit sets one edge after its request is forwarded unmasked and holds until cleared. A level line's bit follows its forwarded request, one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data, zero when not valid |
| irq_in | input | NUM_LINES | Raw interrupt inputs |
| irq_out | output | NUM_LINES | Unmasked active requests |

## Verification
The assertions assume that the bus carries at most one access per cycle and that bus signals are stable across the sampling edge. They also take `bus_addr` of the previous cycle as the address that belongs to the data now in `rd_data`. The bench drives all bus and line inputs at the falling edge, holds `bus_valid` for exactly one cycle per access, and never overlaps a read with a write. It changes polarity and edge settings only while the affected inputs are in a known state, and clears any request that such a change latches before it moves on.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int ADDR_W = 12;
    localparam int WORD_W = 32;
    localparam int REG_W  = 64;

    localparam logic [WORD_W-1:0] IDENT_LO_WORD = 32'h0700_0000;
    localparam logic [15:0]       IDENT_VERSION = 16'h0001;

    // Base offsets of the word pairs; base+4 selects bits 63:32.
    localparam logic [ADDR_W-1:0] OFF_IDENT = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_MSGEN = 12'h040;
    localparam logic [ADDR_W-1:0] OFF_EDGE  = 12'h060;
    localparam logic [ADDR_W-1:0] OFF_CLEAR = 12'h080;
    localparam logic [ADDR_W-1:0] OFF_AUTOA = 12'h0C0;
    localparam logic [ADDR_W-1:0] OFF_AUTOB = 12'h0E0;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 12'h3A0;
    localparam logic [ADDR_W-1:0] OFF_POL   = 12'h3E0;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_RDATA = 1'b1
    } bus_state_e;

    typedef enum logic [3:0] {
        SEL_NONE  = 4'd0,
        SEL_IDENT = 4'd1,
        SEL_MASK  = 4'd2,
        SEL_MSGEN = 4'd3,
        SEL_EDGE  = 4'd4,
        SEL_CLEAR = 4'd5,
        SEL_AUTO  = 4'd6,
        SEL_STAT  = 4'd7,
        SEL_POL   = 4'd8
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] base;
        base = {a[ADDR_W-1:3], 3'b000};
        if (a[1:0] != 2'b00) return SEL_NONE;
        case (base)
            OFF_IDENT:            return SEL_IDENT;
            OFF_MASK:             return SEL_MASK;
            OFF_MSGEN:            return SEL_MSGEN;
            OFF_EDGE:             return SEL_EDGE;
            OFF_CLEAR:            return SEL_CLEAR;
            OFF_AUTOA, OFF_AUTOB: return SEL_AUTO;
            OFF_STAT:             return SEL_STAT;
            OFF_POL:              return SEL_POL;
            default:              return SEL_NONE;
        endcase
    endfunction

    // Which writable setting the r-th configuration register holds.
    function automatic reg_sel_e cfg_sel(input int r);
        case (r)
            0:       return SEL_MASK;
            1:       return SEL_MSGEN;
            2:       return SEL_EDGE;
            default: return SEL_POL;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] pick_half(input logic [REG_W-1:0] v,
                                                    input logic hi);
        return hi ? v[REG_W-1:WORD_W] : v[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/intc_half_reg.sv
module intc_half_reg #(
    parameter logic [63:0] RST_VAL = 64'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    output logic [63:0] q
);
    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam logic IS_HI = (h == 1);
        logic [31:0] word_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= RST_VAL[h*32 +: 32];
            end else if (wr_en && (wr_hi == IS_HI)) begin
                word_q <= wdata;
            end
        end

        assign q[h*32 +: 32] = word_q;
    end
endmodule

// File: rtl/intc_line_ctrl.sv
module intc_line_ctrl #(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [63:0]          edge_sel,
    input  logic [63:0]          pol,
    input  logic [63:0]          mask,
    input  logic [63:0]          clr,
    output logic [63:0]          irr_q,
    output logic [63:0]          isr_q
);
    for (genvar i = 0; i < 64; i++) begin : g_bit
        if (i < NUM_LINES) begin : g_line
            logic adj;
            logic adj_prev;
            logic irr_r;
            logic isr_r;
            logic fwd;
            logic kill;

            assign adj  = irq_in[i] ^ pol[i];
            assign fwd  = irr_r & ~mask[i];
            assign kill = clr[i] & edge_sel[i];

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    adj_prev <= 1'b0;
                    irr_r    <= 1'b0;
                    isr_r    <= 1'b0;
                end else begin
                    adj_prev <= adj;
                    if (edge_sel[i]) begin
                        // A fresh transition wins over a clear in the same cycle.
                        irr_r <= (adj & ~adj_prev) | (irr_r & ~kill);
                        isr_r <= (isr_r | fwd) & ~kill;
                    end else begin
                        irr_r <= adj;
                        isr_r <= fwd;
                    end
                end
            end

            assign irr_q[i] = irr_r;
            assign isr_q[i] = isr_r;
        end else begin : g_absent
            assign irr_q[i] = 1'b0;
            assign isr_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/intc_bus_fsm.sv
module intc_bus_fsm
    import intc_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  mask_q,
    input  logic [REG_W-1:0]  msg_q,
    input  logic [REG_W-1:0]  edge_q,
    input  logic [REG_W-1:0]  pol_q,
    input  logic [REG_W-1:0]  isr_q,
    output logic              acc_wr,
    output logic              acc_hi,
    output reg_sel_e          acc_sel,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    localparam logic [15:0] LINES_M1 = 16'(NUM_LINES - 1);

    bus_state_e        state_q, state_d;
    logic              rd_acc;
    logic [WORD_W-1:0] rd_mux;
    logic [WORD_W-1:0] rdata_q;

    assign acc_sel = decode_sel(bus_addr);
    assign acc_hi  = bus_addr[2];
    assign acc_wr  = bus_valid & bus_write;
    assign rd_acc  = bus_valid & ~bus_write;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:  state_d = rd_acc ? ST_RDATA : ST_IDLE;
            ST_RDATA: state_d = rd_acc ? ST_RDATA : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (acc_sel)
            SEL_IDENT: rd_mux = acc_hi ? {LINES_M1, IDENT_VERSION} : IDENT_LO_WORD;
            SEL_MASK:  rd_mux = pick_half(mask_q, acc_hi);
            SEL_MSGEN: rd_mux = pick_half(msg_q, acc_hi);
            SEL_EDGE:  rd_mux = pick_half(edge_q, acc_hi);
            SEL_STAT:  rd_mux = pick_half(isr_q, acc_hi);
            SEL_POL:   rd_mux = pick_half(pol_q, acc_hi);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_acc) begin
            rdata_q <= rd_mux;
        end
    end

    always_comb begin
        rd_valid = (state_q == ST_RDATA);
        rd_data  = rd_valid ? rdata_q : '0;
    end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic                 rd_valid,
    output logic [31:0]          rd_data,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] irq_out
);
    logic           acc_wr;
    logic           acc_hi;
    reg_sel_e       acc_sel;
    logic [REG_W-1:0] cfg_q [4];
    logic [REG_W-1:0] mask_q, msg_q, edge_q, pol_q;
    logic [REG_W-1:0] irr_q, isr_q, clr_vec;

    intc_bus_fsm #(.NUM_LINES(NUM_LINES)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_valid(bus_valid),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .mask_q   (mask_q),
        .msg_q    (msg_q),
        .edge_q   (edge_q),
        .pol_q    (pol_q),
        .isr_q    (isr_q),
        .acc_wr   (acc_wr),
        .acc_hi   (acc_hi),
        .acc_sel  (acc_sel),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    for (genvar r = 0; r < 4; r++) begin : g_cfg
        localparam reg_sel_e    TGT = cfg_sel(r);
        localparam logic [63:0] RST = (r == 0) ? {64{1'b1}} : 64'h0;

        intc_half_reg #(.RST_VAL(RST)) u_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .wr_en(acc_wr && (acc_sel == TGT)),
            .wr_hi(acc_hi),
            .wdata(bus_wdata),
            .q    (cfg_q[r])
        );
    end

    assign mask_q = cfg_q[0];
    assign msg_q  = cfg_q[1];
    assign edge_q = cfg_q[2];
    assign pol_q  = cfg_q[3];

    always_comb begin
        clr_vec = '0;
        if (acc_wr && (acc_sel == SEL_CLEAR)) begin
            clr_vec = acc_hi ? {bus_wdata, 32'h0} : {32'h0, bus_wdata};
        end
    end

    intc_line_ctrl #(.NUM_LINES(NUM_LINES)) u_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .edge_sel(edge_q),
        .pol     (pol_q),
        .mask    (mask_q),
        .clr     (clr_vec),
        .irr_q   (irr_q),
        .isr_q   (isr_q)
    );

    assign irq_out = irr_q[NUM_LINES-1:0] & ~mask_q[NUM_LINES-1:0];
endmodule

// File: rtl/intc_regs_chk.sv
module intc_regs_chk #(
    parameter int NUM_LINES = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [11:0]          bus_addr,
    input logic [31:0]          bus_wdata,
    input logic                 rd_valid,
    input logic [31:0]          rd_data,
    input logic [NUM_LINES-1:0] irq_out,
    input logic [63:0]          edge_q
);
    localparam int LO_W = (NUM_LINES < 32) ? NUM_LINES : 32;

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_valid && !bus_write)); // R1

    AST_IDENT_LO_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && ($past(bus_addr) == 12'h000)) |-> (rd_data == 32'h0700_0000)); // R3

    AST_AUTO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && (($past(bus_addr) & 12'hFDB) == 12'h0C0)) |-> (rd_data == 32'h0)); // R6

    AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_valid && bus_write && (bus_addr == 12'h020) && (bus_wdata == 32'hFFFF_FFFF))
        |-> (irq_out[LO_W-1:0] == '0)); // R11

    AST_HALF_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_valid && bus_write && (bus_addr == 12'h064))
        |-> (edge_q[31:0] == $past(edge_q[31:0]))); // R5
endmodule

bind intc_regs intc_regs_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .irq_out  (irq_out),
    .edge_q   (edge_q)
);

// File: tb/intc_regs_tb.sv
`timescale 1ns/1ps
module intc_regs_tb;
    localparam int N = 64;

    logic          clk;
    logic          rst_n;
    logic          bus_valid;
    logic          bus_write;
    logic [11:0]   bus_addr;
    logic [31:0]   bus_wdata;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic [N-1:0]  irq_in;
    logic [N-1:0]  irq_out;

    int n_tests = 0;
    int n_fail  = 0;

    intc_regs #(.NUM_LINES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .irq_in(irq_in), .irq_out(irq_out)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        chk("R1 rd_valid after read", 64'(rd_valid), 64'd1);
        d = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
        bus_addr = '0; bus_wdata = '0; irq_in = '0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R7 reset state
        chk("R7 irq_out reset", 64'(irq_out), 64'd0);
        chk("R1 no rd_valid idle", 64'(rd_valid), 64'd0);
        rd(12'h020, d); chk("R7 mask lo reset", 64'(d), 64'hFFFF_FFFF);
        rd(12'h024, d); chk("R7 mask hi reset", 64'(d), 64'hFFFF_FFFF);
        rd(12'h060, d); chk("R7 edge reset", 64'(d), 64'd0);
        rd(12'h044, d); chk("R7 msgen reset", 64'(d), 64'd0);
        rd(12'h3E4, d); chk("R7 pol reset", 64'(d), 64'd0);
        rd(12'h3A0, d); chk("R7 status reset", 64'(d), 64'd0);

        rd(12'h000, d); chk("R3 ident low", 64'(d), 64'h0700_0000);
        rd(12'h004, d); chk("R4 ident high", 64'(d), 64'({16'(N - 1), 16'h0001}));

        // R2 / R5: word placement and half independence for every writable setting
        for (int r = 0; r < 4; r++) begin
            logic [11:0] base;
            logic [31:0] lo_pat, hi_pat, lo_new;
            base   = (r == 0) ? 12'h020 : (r == 1) ? 12'h040 : (r == 2) ? 12'h060 : 12'h3E0;
            lo_pat = 32'hA5A5_0000 ^ (32'h1111 * r);
            hi_pat = ~lo_pat;
            lo_new = 32'h0F0F_F0F0 + r;
            wr(base, lo_pat);
            wr(base + 12'd4, hi_pat);
            rd(base, d);          chk("R2 low word", 64'(d), 64'(lo_pat));
            rd(base + 12'd4, d);  chk("R2 high word", 64'(d), 64'(hi_pat));
            wr(base, lo_new);
            rd(base + 12'd4, d);  chk("R5 high kept", 64'(d), 64'(hi_pat));
            rd(base, d);          chk("R5 low replaced", 64'(d), 64'(lo_new));
            wr(base + 12'd4, 32'h1234_5678);
            rd(base, d);          chk("R5 low kept", 64'(d), 64'(lo_new));
        end
        // Back to a clean configuration; level mode flushes any latched request.
        wr(12'h020, 32'hFFFF_FFFF); wr(12'h024, 32'hFFFF_FFFF);
        wr(12'h3E0, 32'h0); wr(12'h3E4, 32'h0);
        wr(12'h060, 32'h0); wr(12'h064, 32'h0);
        wr(12'h040, 32'h0); wr(12'h044, 32'h0);
        wait_cyc(2);

        // R6 discarded and unmapped words
        for (int k = 0; k < 9; k++) begin
            logic [11:0] a;
            case (k)
                0: a = 12'h0C0; 1: a = 12'h0C4; 2: a = 12'h0E0; 3: a = 12'h0E4;
                4: a = 12'h008; 5: a = 12'h3FC; 6: a = 12'h100; 7: a = 12'h022;
                default: a = 12'h080;
            endcase
            wr(a, 32'hFFFF_FFFF);
            rd(a, d); chk("R6 reads zero", 64'(d), 64'd0);
        end
        rd(12'h020, d); chk("R6 mask untouched", 64'(d), 64'hFFFF_FFFF);
        rd(12'h060, d); chk("R6 edge untouched", 64'(d), 64'd0);
        rd(12'h3E0, d); chk("R6 pol untouched", 64'(d), 64'd0);
        chk("R6 irq_out untouched", 64'(irq_out), 64'd0);

        // R10 / R12 level sweep across every line
        wr(12'h020, 32'h0); wr(12'h024, 32'h0);
        for (int i = 0; i < N; i++) begin
            irq_in = N'(1) << i;
            wait_cyc(2);
            chk("R10 level follows", 64'(irq_out), 64'd1 << i);
            wr((i < 32) ? 12'h080 : 12'h084, 32'd1 << (i % 32));
            chk("R12 clear ignored on level", 64'(irq_out), 64'd1 << i);
            irq_in = '0;
            wait_cyc(2);
            chk("R10 level drops", 64'(irq_out), 64'd0);
        end

        // R9 / R12 / R13 edge sweep across every line
        wr(12'h060, 32'hFFFF_FFFF); wr(12'h064, 32'hFFFF_FFFF);
        for (int i = 0; i < N; i++) begin
            logic [11:0] sa;
            sa = (i < 32) ? 12'h3A0 : 12'h3A4;
            irq_in = N'(1) << i;
            wait_cyc(1);
            irq_in = '0;
            wait_cyc(3);
            chk("R9 edge held", 64'(irq_out), 64'd1 << i);
            rd(sa, d); chk("R13 in-service set", 64'(d), 64'(32'd1 << (i % 32)));
            wr((i < 32) ? 12'h080 : 12'h084, 32'd1 << (i % 32));
            chk("R12 edge cleared", 64'(irq_out), 64'd0);
            wait_cyc(1);
            rd(sa, d); chk("R12 in-service cleared", 64'(d), 64'd0);
        end

        // R8 polarity on a level line (line 5)
        wr(12'h060, 32'h0);
        wr(12'h3E0, 32'h0000_0020);
        wait_cyc(2);
        chk("R8 low input active", 64'(irq_out), 64'd1 << 5);
        irq_in[5] = 1'b1;
        wait_cyc(2);
        chk("R8 high input inactive", 64'(irq_out), 64'd0);
        irq_in[5] = 1'b0;
        wr(12'h3E0, 32'h0);
        wait_cyc(2);
        chk("R8 restored", 64'(irq_out), 64'd0);

        // R8 polarity on an edge line (line 45): a falling input latches
        irq_in[45] = 1'b1;
        wait_cyc(1);
        wr(12'h3E4, 32'd1 << 13);
        wr(12'h084, 32'd1 << 13);
        wait_cyc(1);
        chk("R8 inverted edge idle", 64'(irq_out), 64'd0);
        irq_in[45] = 1'b0;
        wait_cyc(2);
        chk("R8 falling input latches", 64'(irq_out), 64'd1 << 45);
        wr(12'h3E4, 32'h0);
        wr(12'h084, 32'd1 << 13);
        wait_cyc(1);
        chk("R12 cleanup", 64'(irq_out), 64'd0);

        // R11 / R13 masked latch revealed by unmask (line 40)
        wr(12'h024, 32'hFFFF_FFFF);
        irq_in[40] = 1'b1;
        wait_cyc(1);
        irq_in[40] = 1'b0;
        wait_cyc(3);
        chk("R11 masked hidden", 64'(irq_out), 64'd0);
        rd(12'h3A4, d); chk("R13 not in service while masked", 64'(d), 64'd0);
        wr(12'h024, 32'h0);
        chk("R11 unmask reveals", 64'(irq_out), 64'd1 << 40);
        wait_cyc(2);
        rd(12'h3A4, d); chk("R13 in service after unmask", 64'(d), 64'(32'd1 << 8));
        wr(12'h020, 32'hFFFF_FFFF);
        chk("R11 other half unaffected", 64'(irq_out), 64'd1 << 40);
        wr(12'h084, 32'd1 << 8);
        chk("R12 final clear", 64'(irq_out), 64'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule